// File: doc/BRIEF.md
# Rate-Adaptive Turbo Code Puncturer

This block sits between a rate-1/3 turbo encoder and the bit interleaver. Each step it takes one triple: a systematic bit and two parity bits, one from each constituent encoder. It serializes the bits it keeps into one coded stream. Parity bits are removed at evenly spaced positions, so the effective code rate follows a two-bit rate selection. Systematic bits and trellis termination bits always pass through. Padding triples are removed entirely.

Each triple carries a two-bit kind code and a codeword-start flag. It also carries a flag that marks the short tail codewords found at the end of a frame. Short codewords use their own period table, which is less aggressive and so gives a lower code rate than long codewords at the same rate selection. Both period tables are parameters: one entry per rate code, and an entry of zero means that no parity is removed. The input side accepts a new triple only when no bits are left to send. The output is a registered valid/ready bit stream.

Top module: `turbo_puncturer`

## Requirements
- R1: After a synchronous reset, out_valid is low and in_ready is high.
- R2: For an accepted data triple (in_kind 00), the systematic bit is always sent, and it is sent before any parity bit of that triple.
- R3: With cfg_rate 0, both parity bits of every data triple are kept, giving three output bits per data triple in the order systematic, parity 0, parity 1.
- R4: For a long codeword (in_short_cw 0), the parity period P is 1, 3 or 5 for cfg_rate 1, 2 or 3. Data triples are counted from index 0 at the codeword start. The triple with index i keeps one parity bit when i mod P equals P-1. The kept bits alternate between parity 0 and parity 1, starting with parity 0, and each is sent after that triple's systematic bit.
- R5: For a short codeword (in_short_cw 1), cfg_rate 1 removes no parity bits, and cfg_rate 2 and 3 use periods 2 and 3 under the rule of R4.
- R6: A tail triple (in_kind 01) sends all three bits in the order systematic, parity 0, parity 1, and does not advance the parity index.
- R7: A pad triple (in_kind 10) or a reserved triple (in_kind 11) sends nothing and does not advance the parity index.
- R8: An accepted triple of any kind with in_cw_start high restarts the parity index at 0 and the alternation at parity 0.
- R9: in_ready is low whenever out_valid is high, so no triple is taken while bits of an earlier one are pending.
- R10: While out_valid is high and out_ready is low, out_valid and out_bit hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate | input | RATE_W | Rate code selecting the period table entry |
| in_valid | input | 1 | Triple offered |
| in_ready | output | 1 | Triple can be taken |
| in_kind | input | 2 | 00 data, 01 tail, 10 pad, 11 reserved |
| in_cw_start | input | 1 | First triple of a codeword |
| in_short_cw | input | 1 | Triple belongs to a short tail codeword |
| in_sys | input | 1 | Systematic bit |
| in_p0 | input | 1 | Parity bit from the first constituent encoder |
| in_p1 | input | 1 | Parity bit from the second constituent encoder |
| out_valid | output | 1 | Coded bit available |
| out_ready | input | 1 | Downstream takes the coded bit |
| out_bit | output | 1 | Coded bit |

## Verification
The assertions check on every cycle the properties that are local in time. In_ready must stay low while bits are pending, and the output must hold under backpressure. The systematic bit or tail bit must come out first in the cycle after acceptance, and a pad or reserved triple must leave the output silent. Only the bench's scenarios can show the puncturing pattern itself. This covers where the kept parity bits fall within a codeword, the alternation between the two parity streams, and the separate short-codeword table. It also covers the restart at each codeword start and the resulting bit count per codeword. The bench compares every output bit against an independent model and checks each codeword's total against the count implied by its rate.

// File: rtl/turbo_punc_pkg.sv
package turbo_punc_pkg;

  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_TAIL = 2'b01,
    KIND_PAD  = 2'b10,
    KIND_RSVD = 2'b11
  } tp_kind_e;

  // bits per encoder step: systematic, parity 0, parity 1
  localparam int TP_SLOTS = 3;

endpackage

// File: rtl/tpunc_pattern.sv
module tpunc_pattern #(
  parameter int                      RATE_W  = 2,
  parameter int                      CNT_W   = 4,
  parameter logic [(1<<RATE_W)*CNT_W-1:0] LONG_P  = '0,
  parameter logic [(1<<RATE_W)*CNT_W-1:0] SHORT_P = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              clear_en,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  input  logic              short_cw,
  output logic              keep0,
  output logic              keep1
);
  localparam int N_RATES = 1 << RATE_W;

  logic [CNT_W-1:0] long_tab  [N_RATES];
  logic [CNT_W-1:0] short_tab [N_RATES];

  for (genvar g = 0; g < N_RATES; g++) begin : g_tab
    assign long_tab[g]  = LONG_P[g*CNT_W +: CNT_W];
    assign short_tab[g] = SHORT_P[g*CNT_W +: CNT_W];
  end

  logic [CNT_W-1:0] cnt_q, cnt_eff, period;
  logic             sel_q, sel_eff, wrap, no_punc;

  always_comb begin
    period  = short_cw ? short_tab[rate] : long_tab[rate];
    no_punc = (period == '0);
    cnt_eff = restart ? '0 : cnt_q;
    sel_eff = restart ? 1'b0 : sel_q;
    wrap    = !no_punc && (cnt_eff >= period - 1'b1);
    keep0   = no_punc || (wrap && !sel_eff);
    keep1   = no_punc || (wrap && sel_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (step_en) begin
      if (no_punc) begin
        cnt_q <= '0;
        sel_q <= sel_eff;
      end else if (wrap) begin
        cnt_q <= '0;
        sel_q <= !sel_eff;
      end else begin
        cnt_q <= cnt_eff + 1'b1;
        sel_q <= sel_eff;
      end
    end else if (clear_en) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tpunc_serializer.sv
module tpunc_serializer
  import turbo_punc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [TP_SLOTS-1:0] bits,
  input  logic [TP_SLOTS-1:0] mask,
  input  logic                out_ready,
  output logic                out_valid,
  output logic                out_bit,
  output logic                idle
);
  localparam int LW = $clog2(TP_SLOTS + 1);

  logic [TP_SLOTS-1:0] packed_bits, sreg_q;
  logic [LW-1:0]       n_keep, left_q;

  always_comb begin
    packed_bits = '0;
    n_keep      = '0;
    for (int i = 0; i < TP_SLOTS; i++) begin
      if (mask[i]) begin
        packed_bits[n_keep] = bits[i];
        n_keep              = n_keep + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (load) begin
      sreg_q <= packed_bits;
      left_q <= n_keep;
    end else if (left_q != '0 && out_ready) begin
      sreg_q <= sreg_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign out_valid = (left_q != '0);
  assign out_bit   = sreg_q[0];
  assign idle      = (left_q == '0);

endmodule

// File: rtl/turbo_puncturer.sv
module turbo_puncturer
  import turbo_punc_pkg::*;
#(
  parameter int RATE_W = 2,
  parameter int CNT_W  = 4,
  parameter logic [(1<<RATE_W)*CNT_W-1:0] LONG_P  = {4'd5, 4'd3, 4'd1, 4'd0},
  parameter logic [(1<<RATE_W)*CNT_W-1:0] SHORT_P = {4'd3, 4'd2, 4'd0, 4'd0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic              in_cw_start,
  input  logic              in_short_cw,
  input  logic              in_sys,
  input  logic              in_p0,
  input  logic              in_p1,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit
);
  tp_kind_e            kind;
  logic                accept, is_data, is_tail, keep0, keep1, idle;
  logic [TP_SLOTS-1:0] mask;

  assign kind    = tp_kind_e'(in_kind);
  assign accept  = in_valid && idle;
  assign is_data = (kind == KIND_DATA);
  assign is_tail = (kind == KIND_TAIL);

  tpunc_pattern #(
    .RATE_W (RATE_W),
    .CNT_W  (CNT_W),
    .LONG_P (LONG_P),
    .SHORT_P(SHORT_P)
  ) pat_i (
    .clk     (clk),
    .rst     (rst),
    .step_en (accept && is_data),
    .clear_en(accept && in_cw_start),
    .restart (in_cw_start),
    .rate    (cfg_rate),
    .short_cw(in_short_cw),
    .keep0   (keep0),
    .keep1   (keep1)
  );

  always_comb begin
    if (is_tail)      mask = '1;
    else if (is_data) mask = {keep1, keep0, 1'b1};
    else              mask = '0;
  end

  tpunc_serializer ser_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .bits     ({in_p1, in_p0, in_sys}),
    .mask     (mask),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_bit  (out_bit),
    .idle     (idle)
  );

  assign in_ready = idle;

endmodule

// File: rtl/tpunc_checker.sv
module tpunc_checker #(
  parameter int RATE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [RATE_W-1:0] cfg_rate,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_kind,
  input logic              in_sys,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_bit
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (!out_valid && in_ready));

  // R9
  a_r9_no_accept_while_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R10
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R7
  a_r7_pad_silent: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_kind[1]) |=> !out_valid);

  // R2
  a_r2_sys_first: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_kind == 2'b00) |=> (out_valid && out_bit == $past(in_sys)));

  // R6
  a_r6_tail_first: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_kind == 2'b01) |=> (out_valid && out_bit == $past(in_sys)));

  logic unused_rate;
  assign unused_rate = ^cfg_rate;

endmodule

bind turbo_puncturer tpunc_checker #(.RATE_W(RATE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cfg_rate (cfg_rate),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_kind  (in_kind),
  .in_sys   (in_sys),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_bit  (out_bit)
);

// File: tb/turbo_puncturer_tb_top.sv
`timescale 1ns/1ps
module turbo_puncturer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_rate = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_kind = '0;
  logic       in_cw_start = 1'b0;
  logic       in_short_cw = 1'b0;
  logic       in_sys = 1'b0, in_p0 = 1'b0, in_p1 = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       out_bit;

  always #4 clk = ~clk;

  turbo_puncturer dut_i (
    .clk(clk), .rst(rst), .cfg_rate(cfg_rate),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_cw_start(in_cw_start), .in_short_cw(in_short_cw),
    .in_sys(in_sys), .in_p0(in_p0), .in_p1(in_p1),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  int  n_chk = 0, n_bad = 0;
  int  rdy_pct = 100;
  int  out_cnt = 0;
  int  m_cnt = 0;
  bit  m_sel = 1'b0;
  bit  exp_q[$];
  bit  hold_prev = 1'b0, held_bit = 1'b0, accepted = 1'b0;
  bit  done = 1'b0;

  function automatic int period_of(int rate, bit sh);
    if (sh) return (rate == 3) ? 3 : (rate == 2) ? 2 : 0;
    return (rate == 3) ? 5 : (rate == 2) ? 3 : (rate == 1) ? 1 : 0;
  endfunction

  function automatic int cw_bits(int rate, bit sh, int nd, int nt);
    int p = period_of(rate, sh);
    return nd + ((p == 0) ? 2 * nd : nd / p) + 3 * nt;
  endfunction

  task automatic model_push();
    int p;
    if (in_cw_start) begin m_cnt = 0; m_sel = 1'b0; end
    if (in_kind == 2'b01) begin
      exp_q.push_back(in_sys); exp_q.push_back(in_p0); exp_q.push_back(in_p1);
    end else if (in_kind == 2'b00) begin
      p = period_of(int'(cfg_rate), in_short_cw);
      exp_q.push_back(in_sys);
      if (p == 0) begin
        exp_q.push_back(in_p0); exp_q.push_back(in_p1);
      end else if (m_cnt == p - 1) begin
        exp_q.push_back(m_sel ? in_p1 : in_p0);
        m_sel = !m_sel; m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  endtask

  task automatic cycle();
    bit e;
    out_ready = ($urandom_range(99) < rdy_pct);
    @(negedge clk);
    if (hold_prev) begin
      n_chk++;
      if (!out_valid || out_bit !== held_bit) begin
        n_bad++;
        $display("FAIL R10 hold: valid=%0b bit=%0b expected valid=1 bit=%0b", out_valid, out_bit, held_bit);
      end
    end
    if (out_valid) begin
      n_chk++;
      if (in_ready) begin
        n_bad++;
        $display("FAIL R9 in_ready=%0b expected 0 while bits pending", in_ready);
      end
    end
    if (out_valid && out_ready) begin
      n_chk++;
      out_cnt++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2/R4 extra bit %0b, expected none", out_bit);
      end else begin
        e = exp_q.pop_front();
        if (out_bit !== e) begin
          n_bad++;
          $display("FAIL R2/R3/R4/R5/R6/R8 bit=%0b expected %0b", out_bit, e);
        end
      end
    end
    hold_prev = out_valid && !out_ready;
    held_bit  = out_bit;
    accepted  = in_valid && in_ready;
    if (accepted) model_push();
    @(posedge clk);
    #1;
  endtask

  task automatic send(bit [1:0] k, bit cws, bit s, bit a, bit b);
    in_valid = 1'b1; in_kind = k; in_cw_start = cws;
    in_sys = s; in_p0 = a; in_p1 = b;
    accepted = 1'b0;
    while (!accepted) cycle();
    in_valid = 1'b0; in_cw_start = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && (exp_q.size() != 0 || out_valid); i++) cycle();
  endtask

  // data triples, then pads (reserved kind mixed in when rsvd set), then tails
  task automatic run_cw(int rate, bit sh, int nd, int npad, int nt, bit rsvd, bit pad_first, string tag);
    int want;
    cfg_rate = rate[1:0]; in_short_cw = sh; out_cnt = 0;
    if (pad_first) send(2'b10, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < nd; i++)
      send(2'b00, (i == 0) && !pad_first, 1'($urandom), 1'($urandom), 1'($urandom));
    for (int i = 0; i < npad; i++)
      send((rsvd && i[0]) ? 2'b11 : 2'b10, 1'b0, 1'($urandom), 1'($urandom), 1'($urandom));
    for (int i = 0; i < nt; i++)
      send(2'b01, 1'b0, 1'($urandom), 1'($urandom), 1'($urandom));
    drain();
    want = cw_bits(rate, sh, nd, nt);
    n_chk++;
    if (out_cnt != want || exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s bit count=%0d expected %0d (left %0d)", tag, out_cnt, want, exp_q.size());
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
    end
    @(posedge clk); #1;

    run_cw(0, 0, 4, 0, 0, 0, 0, "R3 rate0");
    run_cw(1, 0, 6, 0, 0, 0, 0, "R4 rate1 long");
    run_cw(2, 0, 12, 0, 2, 0, 0, "R4/R6 rate2 long tail");
    run_cw(3, 0, 10, 3, 0, 0, 0, "R4/R7 rate3 long pad");
    run_cw(2, 1, 8, 0, 0, 0, 0, "R5 rate2 short");
    run_cw(3, 1, 9, 0, 3, 0, 0, "R5 rate3 short");
    run_cw(1, 1, 4, 0, 0, 0, 0, "R5 rate1 short");
    run_cw(3, 0, 7, 4, 1, 1, 0, "R7 reserved kind");
    run_cw(2, 0, 5, 0, 0, 0, 1, "R8 start on pad");
    run_cw(3, 0, 4, 0, 0, 0, 0, "R8 restart mid-period");
    rdy_pct = 40;
    run_cw(3, 0, 11, 0, 1, 0, 0, "R10 backpressure");
    rdy_pct = 75;
    for (int c = 0; c < 40; c++)
      run_cw($urandom_range(3), 1'($urandom), $urandom_range(20, 1), $urandom_range(3),
             $urandom_range(3), 1'($urandom), ($urandom_range(7) == 0), "R2/R4/R5 random");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule